// File: doc/BRIEF.md
# SPI Serial Clock Divider

This block produces the timing for an SPI serial clock from the bus clock. Software-visible configuration is reduced to two 3-bit fields. A preselect field scales the bus clock by a linear factor from 1 to 8. An exponent field scales it by a power of two from 2 to 256. The total divide ratio is the product of the two, so it runs from 2 to 2048 and is always even.

Every half period of the serial clock, the block raises a one-cycle toggle enable. It keeps the divided clock level itself, which starts low and inverts on each toggle, so the duty cycle is exactly 50%. Each toggle also comes with a strobe that marks it as a leading edge (level going high) or a trailing edge (level going low). A shifter outside this block uses these strobes for shifting and sampling.

The divider advances only while the transfer-enable input is high. When that input drops, every counter and the clock level return to idle. The next transfer therefore always starts from a full half period.

Top module: `spi_sck_div`

## Requirements
- R1: While `xfer_en` is high and the fields are held, `sck_tick` pulses for exactly one cycle every H bus cycles, where H = (`presel`+1) × 2^`expo`, which is half of the total divisor (`presel`+1) × 2^(`expo`+1).
- R2: The `presel` field scales H linearly: values 0 to 7 give factors 1 to 8.
- R3: The `expo` field scales H by 2^`expo`: values 0 to 7 give factors 1 to 128, which makes the full-period factor 2 to 256.
- R4: After `xfer_en` rises, the first `sck_tick` comes in the H-th enabled cycle. The cycle in which `xfer_en` is first high counts as cycle 1.
- R5: `sck_lvl` is low when idle, inverts on the clock edge that ends each `sck_tick` cycle, and holds its value in every other enabled cycle.
- R6: During a tick, `lead_stb` is high when `sck_lvl` is currently 0 and `trail_stb` is high when `sck_lvl` is currently 1. The two strobes are never high together and are never high without `sck_tick`, so within a transfer they alternate, starting with a leading strobe.
- R7: While `xfer_en` is low, no tick or strobe is produced, and `sck_lvl` is 0 from the edge after `xfer_en` is first sampled low. If a transfer is dropped part-way through a half period, the next one still waits the full H cycles of R4.
- R8: After a synchronous active-low reset, `sck_tick`, `sck_lvl`, `lead_stb` and `trail_stb` are all 0.
- R9: At the extremes, `presel`=0 with `expo`=0 ticks in every enabled cycle (divisor 2), and `presel`=7 with `expo`=7 ticks every 1024 cycles (divisor 2048).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, the only clock of the divider |
| rst_n | input | 1 | Synchronous active-low reset |
| xfer_en | input | 1 | Transfer enable; the divider runs while high and idles when low |
| presel | input | 3 | Linear preselect field; the factor is value+1 |
| expo | input | 3 | Exponent field; the factor is 2^(value+1) over a full period |
| sck_tick | output | 1 | One-cycle toggle enable at each half-period boundary |
| sck_lvl | output | 1 | Divided serial clock level, low when idle |
| lead_stb | output | 1 | Tick that moves the level from low to high |
| trail_stb | output | 1 | Tick that moves the level from high to low |

## Verification
The bench drives the smallest divisor, where a tick in every cycle exposes any off-by-one in the linear reload. A design with that error would tick every other cycle. It also drives the largest divisor, where a binary tap chosen one bit too low or too high halves or doubles the 1024-cycle gap. Mixed settings separate the two factors, so a design that added them instead of multiplying them, or that swapped them, lands on the wrong cycle. A transfer dropped in the middle of a half period catches a divider that keeps its count across transfers: its next first tick would come early. The bench also checks the strobe alternation, which would reveal a level that fails to clear when the enable drops.

// File: rtl/spi_sck_div_pkg.sv
// Package: shared sizing for the SPI clock divider.
// Assumes the exponent field picks a tap in a binary counter whose width
// is 2^EXP_W - 1, so every tap from 2^0 up to 2^(2^EXP_W - 1) exists.
package spi_sck_div_pkg;

    localparam int DEF_PRE_W = 3;
    localparam int DEF_EXP_W = 3;

    // Number of binary counter bits needed for a given exponent field width.
    function automatic int pow_stage_width(input int exp_w);
        return (1 << exp_w) - 1;
    endfunction

endpackage

// File: rtl/sck_lin_stage.sv
// Linear prescaler: counts enabled cycles 0..limit and emits a carry in the
// cycle that reaches the limit, so one carry comes every limit+1 cycles.
// Assumes limit is held while run is high; a limit below the current count
// still produces a carry at once instead of wrapping.
module sck_lin_stage #(
    parameter int PRE_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PRE_W-1:0] limit,
    output logic             carry
);

    logic [PRE_W-1:0] cnt_q;

    // Carry when the count has reached the programmed limit.
    assign carry = run && (cnt_q >= limit);

    // Advance the count, reload to zero after a carry, and idle when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (carry) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/sck_pow_stage.sv
// Power-of-two stage: counts prescaler carries in a binary counter. It
// reports a tap whenever a carry arrives while the low 'sel' bits are all
// ones, that is, once every 2^sel carries.
// Assumes sel is held while run is high.
module sck_pow_stage #(
    parameter int EXP_W = 3,
    parameter int BIN_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             step,
    input  logic [EXP_W-1:0] sel,
    output logic             tap
);

    logic [BIN_W-1:0] cnt_q;
    logic [BIN_W-1:0] bit_ok;

    // Each counter bit either lies above the selected tap or must be set.
    for (genvar i = 0; i < BIN_W; i++) begin : g_tap
        assign bit_ok[i] = (sel <= EXP_W'(i)) || cnt_q[i];
    end

    // A tap needs an incoming carry with all selected low bits at one.
    assign tap = step && (&bit_ok);

    // Count carries; clear whenever the divider is stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/sck_edge_gen.sv
// Edge generator: keeps the divided clock level and labels each toggle as
// a leading (low to high) or trailing (high to low) edge.
// Assumes tick is a one-cycle pulse that is only high while run is high.
module sck_edge_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic lvl,
    output logic lead,
    output logic trail
);

    logic lvl_q;

    // Invert the level on each tick; force it low when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            lvl_q <= 1'b0;
        end else if (tick) begin
            lvl_q <= ~lvl_q;
        end
    end

    // Classify the current tick by the level it is about to leave.
    always_comb begin
        lvl   = lvl_q;
        lead  = tick && !lvl_q;
        trail = tick && lvl_q;
    end

endmodule

// File: rtl/spi_sck_div.sv
// SPI serial clock divider. A linear prescaler of (presel+1) feeds a binary
// stage that taps at 2^expo, so a half period of the serial clock lasts
// (presel+1)*2^expo bus cycles and a full period lasts twice that.
// Assumes presel and expo are held for the whole time xfer_en is high.
module spi_sck_div
    import spi_sck_div_pkg::*;
#(
    parameter int PRE_W = DEF_PRE_W,
    parameter int EXP_W = DEF_EXP_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xfer_en,
    input  logic [PRE_W-1:0] presel,
    input  logic [EXP_W-1:0] expo,
    output logic             sck_tick,
    output logic             sck_lvl,
    output logic             lead_stb,
    output logic             trail_stb
);

    localparam int BIN_W = pow_stage_width(EXP_W);

    logic lin_carry;

    sck_lin_stage #(.PRE_W(PRE_W)) u_lin (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (xfer_en),
        .limit (presel),
        .carry (lin_carry)
    );

    sck_pow_stage #(.EXP_W(EXP_W), .BIN_W(BIN_W)) u_pow (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (xfer_en),
        .step  (lin_carry),
        .sel   (expo),
        .tap   (sck_tick)
    );

    sck_edge_gen u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (xfer_en),
        .tick  (sck_tick),
        .lvl   (sck_lvl),
        .lead  (lead_stb),
        .trail (trail_stb)
    );

endmodule

// File: rtl/spi_sck_div_chk.sv
// Checker for the SPI clock divider: watches only the top-level ports and
// keeps its own count of the gap between ticks.
module spi_sck_div_chk #(
    parameter int PRE_W = 3,
    parameter int EXP_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             xfer_en,
    input logic [PRE_W-1:0] presel,
    input logic [EXP_W-1:0] expo,
    input logic             sck_tick,
    input logic             sck_lvl,
    input logic             lead_stb,
    input logic             trail_stb
);

    logic [31:0] gap_q;
    logic [31:0] half_len;

    // Expected half period computed from the two fields.
    assign half_len = (32'(presel) + 32'd1) << expo;

    // Count the enabled cycles since the last tick or the start of a transfer.
    always_ff @(posedge clk) begin
        if (!rst_n || !xfer_en || sck_tick) begin
            gap_q <= '0;
        end else begin
            gap_q <= gap_q + 32'd1;
        end
    end

    AST_GAP_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        sck_tick |-> (gap_q + 32'd1 == half_len)); // R1

    AST_STB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(lead_stb && trail_stb)); // R6

    AST_STB_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (lead_stb || trail_stb) |-> sck_tick); // R6

    AST_LEAD_FROM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        lead_stb |-> !sck_lvl); // R6

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_en |-> !sck_tick); // R7

    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_en |=> !sck_lvl); // R7

    AST_LVL_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_en && $past(xfer_en) && $past(sck_tick)) |-> (sck_lvl != $past(sck_lvl))); // R5

    AST_LVL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_en && $past(xfer_en) && !$past(sck_tick)) |-> $stable(sck_lvl)); // R5

endmodule

bind spi_sck_div spi_sck_div_chk #(.PRE_W(PRE_W), .EXP_W(EXP_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .xfer_en   (xfer_en),
    .presel    (presel),
    .expo      (expo),
    .sck_tick  (sck_tick),
    .sck_lvl   (sck_lvl),
    .lead_stb  (lead_stb),
    .trail_stb (trail_stb)
);

// File: tb/tb_spi_sck_div.sv
// Scoreboard bench: the driver task pushes the expected tick cycles and edge
// kinds for each transfer; a monitor at the falling edge pops and compares.
module tb_spi_sck_div;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       xfer_en = 1'b0;
    logic [2:0] presel = '0;
    logic [2:0] expo = '0;
    logic       sck_tick, sck_lvl, lead_stb, trail_stb;

    int  cyc = 0;
    int  n_cmp = 0;
    int  n_bad = 0;
    bit  prev_en = 1'b0;
    bit  done = 1'b0;
    int  exp_cyc[$];
    bit  exp_trail[$];
    string exp_tag[$];

    always #2.5 clk = ~clk;

    spi_sck_div dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .xfer_en   (xfer_en),
        .presel    (presel),
        .expo      (expo),
        .sck_tick  (sck_tick),
        .sck_lvl   (sck_lvl),
        .lead_stb  (lead_stb),
        .trail_stb (trail_stb)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // Driver: one transfer of 'len' enabled cycles, pushing every expected tick.
    task automatic run_xfer(input int p, input int e, input int len, input string tag);
        int h;
        int start;
        h = (p + 1) << e;
        @(posedge clk);
        #1;
        start  = cyc;
        presel = 3'(p);
        expo   = 3'(e);
        xfer_en = 1'b1;
        for (int k = 1; k * h <= len; k++) begin
            exp_cyc.push_back(start + k * h - 1);
            exp_trail.push_back((k % 2) == 0);
            exp_tag.push_back(tag);
        end
        repeat (len) @(posedge clk);
        #1;
        xfer_en = 1'b0;
        repeat (4) @(posedge clk);
    endtask

    // Monitor: compare each tick with the scoreboard and check quiet idle.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (sck_tick) begin
                n_cmp++;
                if (exp_cyc.size() == 0) begin
                    n_bad++;
                    $display("FAIL R7: tick at cycle %0d, expected none", cyc);
                end else begin
                    int    ec;
                    bit    et;
                    string tg;
                    ec = exp_cyc.pop_front();
                    et = exp_trail.pop_front();
                    tg = exp_tag.pop_front();
                    if (ec != cyc) begin
                        n_bad++;
                        $display("FAIL %s: tick at cycle %0d, expected %0d", tg, cyc, ec);
                    end
                    if (lead_stb != !et || trail_stb != et || sck_lvl != et) begin
                        n_bad++;
                        $display("FAIL R6: lead/trail/lvl = %0b%0b%0b, expected %0b%0b%0b",
                                 lead_stb, trail_stb, sck_lvl, !et, et, et);
                    end
                end
            end
            if (!xfer_en && !prev_en) begin
                n_cmp++;
                if (sck_lvl || lead_stb || trail_stb) begin
                    n_bad++;
                    $display("FAIL R7: idle lvl/lead/trail = %0b%0b%0b, expected 000",
                             sck_lvl, lead_stb, trail_stb);
                end
            end
            prev_en = xfer_en;
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: run hung, cycle %0d, expected end before", cyc);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R8: reset state at the ports
        n_cmp++;
        if (sck_tick || sck_lvl || lead_stb || trail_stb) begin
            n_bad++;
            $display("FAIL R8: outputs %0b%0b%0b%0b, expected 0000",
                     sck_tick, sck_lvl, lead_stb, trail_stb);
        end
        #1;
        rst_n = 1'b1;
        repeat (2) @(posedge clk);

        run_xfer(0, 0, 10, "R9");     // divisor 2: tick every cycle
        run_xfer(7, 0, 40, "R2");     // linear factor 8
        run_xfer(0, 7, 520, "R3");    // power factor 128
        run_xfer(3, 2, 50, "R4");     // H=16, dropped part-way through
        run_xfer(3, 2, 40, "R7");     // restart gets a full first half period
        run_xfer(2, 3, 100, "R1");    // H=24
        run_xfer(5, 1, 60, "R1");     // H=12
        run_xfer(7, 7, 4100, "R9");   // divisor 2048

        repeat (4) @(negedge clk);
        // R1: every scheduled tick must have appeared
        n_cmp++;
        if (exp_cyc.size() != 0) begin
            n_bad++;
            $display("FAIL R1: %0d ticks missing, expected 0", exp_cyc.size());
        end
        finish_run();
    end

endmodule